// File: doc/BRIEF.md
# Nibble-Multiplexed Full-Duplex Data Interface

This block connects a 12-bit transmit and receive datapath to a pair of narrow 6-bit ports. Every word crosses a port as two nibbles on consecutive cycles of an interface clock. That clock runs at twice the word rate and is made inside the block by dividing the core clock by two. On the transmit side, nibbles and a sync strobe are sampled on each rising edge of the interface clock. Each nibble pair is joined back into a 12-bit word and handed to the datapath with a one-cycle valid pulse.

On the receive side, the block takes a 12-bit word from the datapath every second nibble period and splits it into two nibbles. It also drives a sync flag that marks the first nibble of each word.

Static configuration inputs set four things:
- which half of the word travels first;
- the polarity of the receive sync flag;
- whether receive data is launched on the rising or the falling edge of the interface clock;
- whether words are converted between straight binary and two's complement.

A loopback mode sends the captured transmit nibbles and sync straight back out of the receive port.

Top module: `nibif_duplex`

## Requirements
- R1: Out of reset `nib_clk_o`, `tx_valid_o`, `rx_nib_o` and the internal receive sync are 0. After reset is released, `nib_clk_o` toggles on every `clk` rising edge, so it first goes high at the first edge.
- R2: Transmit nibbles and `tx_sync_i` are sampled at the `clk` edges where `nib_clk_o` rises, which are the edges where it was 0 before the edge. With `cfg_lo_first`=0, the nibble sampled with `tx_sync_i`=1 becomes word bits 11:6 and the following nibble becomes bits 5:0.
- R3: With `cfg_lo_first`=1, the first nibble (the one marked by sync) is bits 5:0 and the second nibble is bits 11:6. This holds on both the transmit and the receive side.
- R4: After the second nibble of a pair is sampled, `tx_valid_o` is high for exactly one `clk` cycle with the word on `tx_word_o`. A nibble sampled with sync low and no first nibble pending is ignored and produces no valid pulse.
- R5: If sync is high on a nibble that was expected to be a second nibble, the pending half word is discarded. That nibble becomes the first nibble of a new word.
- R6: With `cfg_twos`=1, bit 11 of the word is inverted in both directions, converting between offset binary and two's complement. Bits 10:0 pass unchanged.
- R7: On the receive side, `rx_word_i` is sampled on the launch edge where `rx_take_o` is high, which occurs once every two nibble periods. The first nibble is driven with the sync flag active and the second with it inactive. With `cfg_neg_launch`=0, `rx_nib_o` changes only at edges after which `nib_clk_o` is 1.
- R8: With `cfg_neg_launch`=1, receive nibbles and sync change only at edges after which `nib_clk_o` is 0.
- R9: With `cfg_sync_inv`=0 the active receive sync level is 1. With `cfg_sync_inv`=1 `rx_sync_o` is inverted, so the active level is 0.
- R10: With `cfg_loopback`=1, `rx_nib_o` and `rx_sync_o` (the sync XOR `cfg_sync_inv`) show the transmit nibble and sync sampled at the most recent rising edge of `nib_clk_o`. This does not depend on `cfg_neg_launch` or `rx_word_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at twice the nibble rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo_first | input | 1 | 1: low half of the word travels first |
| cfg_sync_inv | input | 1 | 1: receive sync is active low |
| cfg_neg_launch | input | 1 | 1: receive data is launched on the falling edge of the nibble clock |
| cfg_twos | input | 1 | 1: invert the word MSB (two's complement conversion) |
| cfg_loopback | input | 1 | 1: transmit port is looped to the receive port |
| tx_nib_i | input | 6 | Transmit nibble port |
| tx_sync_i | input | 1 | Transmit sync, high on the first nibble of a word |
| tx_word_o | output | 12 | Assembled transmit word |
| tx_valid_o | output | 1 | One-cycle pulse when `tx_word_o` holds a new word |
| rx_word_i | input | 12 | Receive word from the datapath |
| rx_take_o | output | 1 | High in the cycle whose closing edge samples `rx_word_i` |
| rx_nib_o | output | 6 | Receive nibble port |
| rx_sync_o | output | 1 | Receive sync flag |
| nib_clk_o | output | 1 | Interface nibble clock, `clk` divided by two |

## Verification
Four properties are checked on every cycle:
- the nibble clock toggles on every edge;
- each valid pulse lasts one cycle and follows a capture edge;
- the receive nibble holds between launch edges and words are taken no more often than every other launch;
- in loopback the receive port follows the transmit nibble.

The bench scenarios cover the behaviour that depends on values:
- the bit placement of each nibble under both nibble orders;
- the MSB conversion;
- realignment after a misplaced sync and the discarding of stray nibbles;
- which phase of the nibble clock each launch edge lands on;
- the inverted sync level.

// File: rtl/nibif_pkg.sv
package nibif_pkg;
  typedef struct packed {
    logic lo_first;
    logic sync_inv;
    logic neg_launch;
    logic twos;
    logic loopback;
  } nibif_cfg_t;
endpackage

// File: rtl/nibif_clkgen.sv
module nibif_clkgen (
  input  logic clk,
  input  logic rst_n,
  input  logic neg_launch,
  output logic ph_o,
  output logic cap_o,
  output logic launch_o
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign ph_o     = ph_q;
  // the nibble clock rises at edges where it is currently low
  assign cap_o    = ~ph_q;
  assign launch_o = neg_launch ? ph_q : ~ph_q;
endmodule

// File: rtl/nibif_tx_asm.sv
module nibif_tx_asm #(
  parameter int unsigned NIB_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic                 lo_first,
  input  logic                 twos,
  input  logic [NIB_W-1:0]     nib,
  input  logic                 sync,
  output logic [2*NIB_W-1:0]   word_o,
  output logic                 valid_o,
  output logic [NIB_W-1:0]     lb_nib_o,
  output logic                 lb_sync_o
);
  localparam int unsigned WORD_W = 2 * NIB_W;

  function automatic logic [WORD_W-1:0] join2(input logic [NIB_W-1:0] a,
                                              input logic [NIB_W-1:0] b,
                                              input logic lo);
    return lo ? {b, a} : {a, b};
  endfunction

  function automatic logic [WORD_W-1:0] msb_flip(input logic [WORD_W-1:0] w,
                                                 input logic en);
    logic [WORD_W-1:0] r;
    r = w;
    r[WORD_W-1] = w[WORD_W-1] ^ en;
    return r;
  endfunction

  logic             have_q;
  logic [NIB_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q    <= 1'b0;
      first_q   <= '0;
      word_o    <= '0;
      valid_o   <= 1'b0;
      lb_nib_o  <= '0;
      lb_sync_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap) begin
        lb_nib_o  <= nib;
        lb_sync_o <= sync;
        if (sync) begin
          first_q <= nib;
          have_q  <= 1'b1;
        end else if (have_q) begin
          word_o  <= msb_flip(join2(first_q, nib, lo_first), twos);
          valid_o <= 1'b1;
          have_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/nibif_rx_split.sv
module nibif_rx_split #(
  parameter int unsigned NIB_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 lo_first,
  input  logic                 twos,
  input  logic [2*NIB_W-1:0]   word_i,
  output logic [NIB_W-1:0]     nib_o,
  output logic                 first_o,
  output logic                 take_o
);
  localparam int unsigned WORD_W = 2 * NIB_W;

  function automatic logic [NIB_W-1:0] pick(input logic [WORD_W-1:0] w,
                                            input logic lo,
                                            input logic second);
    return (lo ^ second) ? w[NIB_W-1:0] : w[WORD_W-1:NIB_W];
  endfunction

  logic              sel_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] conv_w;

  always_comb begin
    conv_w = word_i;
    conv_w[WORD_W-1] = word_i[WORD_W-1] ^ twos;
  end

  assign take_o = launch & ~sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      hold_q  <= '0;
      nib_o   <= '0;
      first_o <= 1'b0;
    end else if (launch) begin
      if (!sel_q) begin
        hold_q  <= conv_w;
        nib_o   <= pick(conv_w, lo_first, 1'b0);
        first_o <= 1'b1;
        sel_q   <= 1'b1;
      end else begin
        nib_o   <= pick(hold_q, lo_first, 1'b1);
        first_o <= 1'b0;
        sel_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nibif_duplex.sv
module nibif_duplex #(
  parameter int unsigned NIB_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_lo_first,
  input  logic                 cfg_sync_inv,
  input  logic                 cfg_neg_launch,
  input  logic                 cfg_twos,
  input  logic                 cfg_loopback,
  input  logic [NIB_W-1:0]     tx_nib_i,
  input  logic                 tx_sync_i,
  output logic [2*NIB_W-1:0]   tx_word_o,
  output logic                 tx_valid_o,
  input  logic [2*NIB_W-1:0]   rx_word_i,
  output logic                 rx_take_o,
  output logic [NIB_W-1:0]     rx_nib_o,
  output logic                 rx_sync_o,
  output logic                 nib_clk_o
);
  import nibif_pkg::*;

  nibif_cfg_t       cfg;
  logic             cap_w;
  logic             launch_w;
  logic [NIB_W-1:0] lb_nib_w;
  logic             lb_sync_w;
  logic [NIB_W-1:0] split_nib_w;
  logic             split_first_w;

  assign cfg = '{lo_first: cfg_lo_first, sync_inv: cfg_sync_inv,
                 neg_launch: cfg_neg_launch, twos: cfg_twos,
                 loopback: cfg_loopback};

  nibif_clkgen i_clkgen (
    .clk(clk), .rst_n(rst_n), .neg_launch(cfg.neg_launch),
    .ph_o(nib_clk_o), .cap_o(cap_w), .launch_o(launch_w)
  );

  nibif_tx_asm #(.NIB_W(NIB_W)) i_tx (
    .clk(clk), .rst_n(rst_n), .cap(cap_w), .lo_first(cfg.lo_first),
    .twos(cfg.twos), .nib(tx_nib_i), .sync(tx_sync_i),
    .word_o(tx_word_o), .valid_o(tx_valid_o),
    .lb_nib_o(lb_nib_w), .lb_sync_o(lb_sync_w)
  );

  nibif_rx_split #(.NIB_W(NIB_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .lo_first(cfg.lo_first),
    .twos(cfg.twos), .word_i(rx_word_i),
    .nib_o(split_nib_w), .first_o(split_first_w), .take_o(rx_take_o)
  );

  assign rx_nib_o  = cfg.loopback ? lb_nib_w : split_nib_w;
  assign rx_sync_o = (cfg.loopback ? lb_sync_w : split_first_w) ^ cfg.sync_inv;
endmodule

// File: rtl/nibif_chk.sv
module nibif_chk #(
  parameter int unsigned NIB_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_loopback,
  input logic [NIB_W-1:0] tx_nib_i,
  input logic             tx_valid_o,
  input logic             rx_take_o,
  input logic [NIB_W-1:0] rx_nib_o,
  input logic             nib_clk_o,
  input logic             cap_w,
  input logic             launch_w
);
  // R1: nibble clock toggles on every edge after reset release
  p_nibclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (nib_clk_o != $past(nib_clk_o)));

  // R4: valid is a single-cycle pulse
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |=> !tx_valid_o);

  // R4: valid only follows a capture edge
  p_valid_after_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(cap_w));

  // R7: receive nibble holds between launch edges
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_loopback && !launch_w) |=> (cfg_loopback || $stable(rx_nib_o)));

  // R7: a word is taken at most every other launch
  p_take_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take_o |=> !rx_take_o);

  // R10: loopback drives the captured transmit nibble
  p_lb_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loopback && cap_w) |=> (!cfg_loopback || rx_nib_o == $past(tx_nib_i)));
endmodule

bind nibif_duplex nibif_chk #(.NIB_W(NIB_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_loopback(cfg_loopback),
  .tx_nib_i(tx_nib_i), .tx_valid_o(tx_valid_o), .rx_take_o(rx_take_o),
  .rx_nib_o(rx_nib_o), .nib_clk_o(nib_clk_o),
  .cap_w(cap_w), .launch_w(launch_w)
);

// File: tb/test_nibif_duplex.sv
module test_nibif_duplex;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_lo_first = 1'b0, cfg_sync_inv = 1'b0, cfg_neg_launch = 1'b0;
  logic        cfg_twos = 1'b0, cfg_loopback = 1'b0;
  logic [5:0]  tx_nib_i = '0;
  logic        tx_sync_i = 1'b0;
  logic [11:0] rx_word_i = '0;
  logic [11:0] tx_word_o;
  logic        tx_valid_o, rx_take_o, rx_sync_o, nib_clk_o;
  logic [5:0]  rx_nib_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nibif_duplex i_nibif_duplex (
    .clk(clk), .rst_n(rst_n), .cfg_lo_first(cfg_lo_first),
    .cfg_sync_inv(cfg_sync_inv), .cfg_neg_launch(cfg_neg_launch),
    .cfg_twos(cfg_twos), .cfg_loopback(cfg_loopback),
    .tx_nib_i(tx_nib_i), .tx_sync_i(tx_sync_i),
    .tx_word_o(tx_word_o), .tx_valid_o(tx_valid_o),
    .rx_word_i(rx_word_i), .rx_take_o(rx_take_o),
    .rx_nib_o(rx_nib_o), .rx_sync_o(rx_sync_o), .nib_clk_o(nib_clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_nib(input logic [5:0] n, input logic s);
    @(negedge clk);
    while (nib_clk_o !== 1'b0) @(negedge clk);
    tx_nib_i  = n;
    tx_sync_i = s;
    @(posedge clk);
  endtask

  task automatic send_word(input logic [11:0] w, input logic [11:0] exp, input string req);
    logic [5:0] a, b;
    a = cfg_lo_first ? w[5:0] : w[11:6];
    b = cfg_lo_first ? w[11:6] : w[5:0];
    send_nib(a, 1'b1);
    @(negedge clk);
    chk(tx_valid_o == 1'b0, req, tx_valid_o, 0);
    send_nib(b, 1'b0);
    @(negedge clk);
    chk(tx_valid_o == 1'b1, req, tx_valid_o, 1);
    chk(tx_word_o == exp, req, tx_word_o, exp);
    @(negedge clk);
    chk(tx_valid_o == 1'b0, {req, " pulse"}, tx_valid_o, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(nib_clk_o == 1'b0, "R1 clk", nib_clk_o, 0);
    chk(tx_valid_o == 1'b0, "R1 valid", tx_valid_o, 0);
    chk(rx_nib_o == 6'h0, "R1 nib", rx_nib_o, 0);
    chk(rx_sync_o == 1'b0, "R1 sync", rx_sync_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nib_clk_o == 1'b1, "R1 toggle", nib_clk_o, 1);
    @(negedge clk);
    chk(nib_clk_o == 1'b0, "R1 toggle", nib_clk_o, 0);
  endtask

  task automatic t_tx_hi_first;
    cfg_lo_first = 1'b0;
    send_word(12'hA5C, 12'hA5C, "R2");
    send_word(12'h0FF, 12'h0FF, "R2");
  endtask

  task automatic t_tx_lo_first;
    cfg_lo_first = 1'b1;
    send_word(12'h3C7, 12'h3C7, "R3");
    cfg_lo_first = 1'b0;
  endtask

  task automatic t_stray_realign;
    send_nib(6'h15, 1'b0);
    @(negedge clk);
    chk(tx_valid_o == 1'b0, "R4 stray", tx_valid_o, 0);
    repeat (2) @(negedge clk);
    chk(tx_valid_o == 1'b0, "R4 stray", tx_valid_o, 0);
    send_nib(6'h2A, 1'b1);
    @(negedge clk);
    chk(tx_valid_o == 1'b0, "R5 first", tx_valid_o, 0);
    send_nib(6'h11, 1'b1);
    @(negedge clk);
    chk(tx_valid_o == 1'b0, "R5 realign", tx_valid_o, 0);
    send_nib(6'h22, 1'b0);
    @(negedge clk);
    chk(tx_valid_o == 1'b1, "R5 valid", tx_valid_o, 1);
    chk(tx_word_o == 12'h462, "R5 word", tx_word_o, 12'h462);
  endtask

  task automatic t_twos_tx;
    cfg_twos = 1'b1;
    send_word(12'h123, 12'h923, "R6 tx");
    send_word(12'hFFF, 12'h7FF, "R6 tx");
    cfg_twos = 1'b0;
  endtask

  task automatic rx_expect(input logic [11:0] w, input string req);
    logic [11:0] cw;
    logic [5:0]  a, b;
    logic        act;
    int          guard;
    cw = w ^ (cfg_twos ? 12'h800 : 12'h000);
    a  = cfg_lo_first ? cw[5:0] : cw[11:6];
    b  = cfg_lo_first ? cw[11:6] : cw[5:0];
    act = ~cfg_sync_inv;
    rx_word_i = w;
    repeat (8) @(negedge clk);
    guard = 0;
    while (rx_sync_o == act && guard < 10) begin @(negedge clk); guard++; end
    while (rx_sync_o != act && guard < 10) begin @(negedge clk); guard++; end
    chk(guard < 10, {req, " sync seen"}, guard, 0);
    chk(nib_clk_o == ~cfg_neg_launch, {req, " edge"}, nib_clk_o, ~cfg_neg_launch);
    chk(rx_nib_o == a, {req, " first"}, rx_nib_o, a);
    repeat (2) @(negedge clk);
    chk(rx_nib_o == b, {req, " second"}, rx_nib_o, b);
    chk(rx_sync_o == ~act, {req, " sync off"}, rx_sync_o, ~act);
  endtask

  task automatic t_rx_modes;
    int takes;
    cfg_lo_first = 1'b0; cfg_neg_launch = 1'b0;
    rx_expect(12'hB71, "R7");
    takes = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (rx_take_o) takes++; end
    chk(takes == 2, "R7 take rate", takes, 2);
    cfg_lo_first = 1'b1;
    rx_expect(12'h4D2, "R3 rx");
    cfg_lo_first = 1'b0;
    cfg_neg_launch = 1'b1;
    rx_expect(12'h96E, "R8");
    cfg_neg_launch = 1'b0;
    cfg_twos = 1'b1;
    rx_expect(12'h2B4, "R6 rx");
    cfg_twos = 1'b0;
    cfg_sync_inv = 1'b1;
    rx_expect(12'hC3A, "R9");
    cfg_sync_inv = 1'b0;
  endtask

  task automatic t_loopback;
    cfg_loopback = 1'b1;
    rx_word_i = 12'hFFF;
    send_nib(6'h2D, 1'b1);
    @(negedge clk);
    chk(rx_nib_o == 6'h2D, "R10 nib", rx_nib_o, 6'h2D);
    chk(rx_sync_o == 1'b1, "R10 sync", rx_sync_o, 1);
    cfg_neg_launch = 1'b1;
    send_nib(6'h13, 1'b0);
    @(negedge clk);
    chk(rx_nib_o == 6'h13, "R10 neg nib", rx_nib_o, 6'h13);
    chk(rx_sync_o == 1'b0, "R10 neg sync", rx_sync_o, 0);
    cfg_sync_inv = 1'b1;
    send_nib(6'h07, 1'b1);
    @(negedge clk);
    chk(rx_nib_o == 6'h07, "R10 inv nib", rx_nib_o, 6'h07);
    chk(rx_sync_o == 1'b0, "R10 inv sync", rx_sync_o, 0);
    cfg_sync_inv = 1'b0; cfg_neg_launch = 1'b0; cfg_loopback = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_hi_first();
    t_tx_lo_first();
    t_stray_realign();
    t_twos_tx();
    t_rx_modes();
    t_loopback();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule